// File: doc/BRIEF.md
# Quadrature to up/down pulse converter

This block watches the two phase lines of an incremental encoder with a system clock that runs much faster than the encoder edges. Each phase line is first brought into the clock domain by a flop chain. It then passes a stability filter, which takes a new level only after that level has been seen on several consecutive samples. The filtered two-bit phase is compared with the value it held one cycle earlier. Every legal one-bit step produces a single-clock pulse: a forward step drives one output, and a reverse step drives a separate output.

Because the two directions leave on separate wires, a system can count position with two plain event counters and subtract one from the other. Every edge of either phase is counted, which gives four counts per electrical cycle. A step in which both filtered bits change in the same sample cannot be decoded. It produces no count and raises a one-cycle error flag.

Top module: `quad_pulse_converter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `up_pulse`, `down_pulse` and `bad_step` are low. Reset takes the filtered phase to {A,B} = 00, so inputs held at 00 through reset produce no pulse.
- R2: With the phase written as {A,B}, the steps 00→01, 01→11, 11→10 and 10→00 are forward. Each one raises `up_pulse` for exactly one clock and leaves `down_pulse` low.
- R3: The steps 00→10, 10→11, 11→01 and 01→00 are reverse. Each one raises `down_pulse` for exactly one clock and leaves `up_pulse` low.
- R4: A change on an input that is held steady afterwards produces its pulse exactly SYNC_STAGES+FILT_LEN+1 rising edges after the input change, counting the first edge that sees the new level as edge one. With the defaults this is edge six. The pulse is low after edge five and low again after edge seven.
- R5: A change on one input that lasts fewer than FILT_LEN clock cycles before it returns produces no pulse. The filtered phase stays as it was, so the next legal step is decoded from the old phase.
- R6: If both filtered bits change in the same sample, neither `up_pulse` nor `down_pulse` rises. `bad_step` goes high for exactly one clock. The new phase becomes the reference for the steps that follow.
- R7: In any cycle at most one of `up_pulse`, `down_pulse` and `bad_step` is high.
- R8: A full forward electrical cycle yields four up pulses, and a full reverse cycle yields four down pulses. Over any walk of legal steps, the up count minus the down count equals the net number of forward steps.
- R9: While both inputs are held constant, no output pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| up_pulse | output | 1 | One-clock pulse per forward step |
| down_pulse | output | 1 | One-clock pulse per reverse step |
| bad_step | output | 1 | One-clock flag for a step in which both bits change together |

## Verification
The assertions on single steps assume that the filtered phase never moves by more than it legally can in one sample. They also assume that each filtered level has been stable on its input for the full filter length before it changes. The bench stays within these limits. After every change it holds the inputs for at least SYNC_STAGES+FILT_LEN+3 clocks, and it drives glitches only as short pulses on a single line. Two-bit jumps are driven on purpose, as simultaneous changes of both inputs, and the bench checks the error flag for each of them rather than treating them as forbidden stimulus.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    typedef logic [1:0] phase_t;   // bit 1 = A, bit 0 = B

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_FWD,
        STEP_REV,
        STEP_BAD
    } step_e;

    // Forward successor in the Gray sequence 00,01,11,10
    function automatic phase_t fwd_of(phase_t p);
        return {p[0], ~p[1]};
    endfunction

    function automatic step_e classify(phase_t prev, phase_t cur);
        if (cur == prev)               return STEP_HOLD;
        else if (cur == fwd_of(prev))  return STEP_FWD;
        else if (prev == fwd_of(cur))  return STEP_REV;
        else                           return STEP_BAD;
    endfunction

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    typedef logic [STAGES-1:0][WIDTH-1:0] pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign synced = pipe_q[STAGES-1];

endmodule

// File: rtl/qpc_filter.sv
module qpc_filter #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    output logic level
);
    localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(LEN - 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample != st_q.level) begin
            if (st_q.cnt == LIMIT) begin
                st_d.level = sample;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign level = st_q.level;

    // A new level is only taken after the disagreeing sample ran the full window
    assert_settled_change_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q.level != $past(st_q.level)) |->
            ($past(st_q.cnt) == LIMIT && $past(sample) == st_q.level));

endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
    import qpc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase,
    output logic   up,
    output logic   down,
    output logic   bad
);
    typedef struct packed {
        phase_t prev;
        logic   up;
        logic   down;
        logic   bad;
    } dec_t;

    dec_t st_d, st_q;
    step_e step;

    always_comb begin
        step       = classify(st_q.prev, phase);
        st_d.prev  = phase;
        st_d.up    = (step == STEP_FWD);
        st_d.down  = (step == STEP_REV);
        st_d.bad   = (step == STEP_BAD);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign up   = st_q.up;
    assign down = st_q.down;
    assign bad  = st_q.bad;

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st_q.up, st_q.down, st_q.bad}));

    assert_up_one_bit_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.up |-> ($countones(st_q.prev ^ $past(st_q.prev)) == 1));

    assert_down_one_bit_R3: assert property (@(posedge clk) disable iff (rst)
        st_q.down |-> ($countones(st_q.prev ^ $past(st_q.prev)) == 1));

    assert_bad_two_bits_R6: assert property (@(posedge clk) disable iff (rst)
        st_q.bad |-> ($countones(st_q.prev ^ $past(st_q.prev)) == 2));

    assert_quiet_when_still_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q.prev == $past(st_q.prev)) |-> !(st_q.up || st_q.down || st_q.bad));

endmodule

// File: rtl/quad_pulse_converter.sv
module quad_pulse_converter
    import qpc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic enc_a,
    input  logic enc_b,
    output logic up_pulse,
    output logic down_pulse,
    output logic bad_step
);
    localparam int NBITS = $bits(phase_t);

    phase_t raw_ph, sync_ph, filt_ph;

    assign raw_ph = {enc_a, enc_b};

    qpc_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (NBITS)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_ph),
        .synced (sync_ph)
    );

    for (genvar i = 0; i < NBITS; i++) begin : g_filt
        qpc_filter #(
            .LEN (FILT_LEN)
        ) u_filt (
            .clk    (clk),
            .rst    (rst),
            .sample (sync_ph[i]),
            .level  (filt_ph[i])
        );
    end

    qpc_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .phase (filt_ph),
        .up    (up_pulse),
        .down  (down_pulse),
        .bad   (bad_step)
    );

endmodule

// File: tb/tb_quad_pulse_converter.sv
module tb_quad_pulse_converter;

    localparam int SYNC = 2;
    localparam int FLEN = 3;
    localparam int LAT  = SYNC + FLEN + 1;
    localparam int HOLD = LAT + 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a = 1'b0;
    logic b = 1'b0;
    logic up, dn, bad;

    int checks = 0;
    int errors = 0;
    int pos    = 0;
    int tot_up = 0;
    int tot_dn = 0;
    logic [1:0] cur = 2'b00;

    always #5 clk = ~clk;

    quad_pulse_converter #(.SYNC_STAGES(SYNC), .FILT_LEN(FLEN)) dut (
        .clk(clk), .rst(rst), .enc_a(a), .enc_b(b),
        .up_pulse(up), .down_pulse(dn), .bad_step(bad)
    );

    // Independent model of the forward sequence 00 -> 01 -> 11 -> 10 -> 00
    function automatic logic [1:0] ahead(logic [1:0] p);
        case (p)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] behind(logic [1:0] p);
        case (p)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive a phase, watch HOLD cycles, compare pulse counts and widths
    task automatic apply(logic [1:0] ph, int e_up, int e_dn, int e_bad, string req);
        int n_up = 0, n_dn = 0, n_bad = 0, multi = 0, run = 0, max_run = 0;
        @(negedge clk);
        {a, b} = ph;
        for (int i = 0; i < HOLD; i++) begin
            @(negedge clk);
            n_up  += int'(up);
            n_dn  += int'(dn);
            n_bad += int'(bad);
            if (int'(up) + int'(dn) + int'(bad) > 1) multi++;
            if (up || dn || bad) run++; else run = 0;
            if (run > max_run) max_run = run;
        end
        tot_up += n_up;
        tot_dn += n_dn;
        cur = ph;
        check_eq({req, " up count"}, n_up, e_up);
        check_eq({req, " down count"}, n_dn, e_dn);
        check_eq({req, " bad count"}, n_bad, e_bad);
        check_eq("R7 exclusive outputs", multi, 0);
        if (e_up + e_dn + e_bad > 0) check_eq({req, " pulse width"}, max_run, 1);
    endtask

    task automatic glitch(logic [1:0] mask, int width);
        int n = 0;
        @(negedge clk);
        {a, b} = cur ^ mask;
        repeat (width) @(negedge clk);
        {a, b} = cur;
        for (int i = 0; i < HOLD; i++) begin
            @(negedge clk);
            n += int'(up) + int'(dn) + int'(bad);
        end
        check_eq("R5 glitch ignored", n, 0);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int quiet;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (4) @(negedge clk);
        check_eq("R1 up in reset", int'(up), 0);
        check_eq("R1 down in reset", int'(dn), 0);
        check_eq("R1 bad in reset", int'(bad), 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 outputs after reset", int'(up) + int'(dn) + int'(bad), 0);

        // R9: inputs held still
        quiet = 0;
        repeat (20) begin
            @(negedge clk);
            quiet += int'(up) + int'(dn) + int'(bad);
        end
        check_eq("R9 no pulse while still", quiet, 0);

        // R4: latency of a single forward step 00 -> 01
        {a, b} = 2'b01;
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        check_eq("R4 not yet", int'(up), 0);
        @(posedge clk);
        @(negedge clk);
        check_eq("R4 pulse on time", int'(up), 1);
        @(posedge clk);
        @(negedge clk);
        check_eq("R4 pulse ended R2", int'(up), 0);
        repeat (HOLD) @(negedge clk);
        cur = 2'b01;
        tot_up++;
        pos++;

        // R2 and R8: full forward cycle from 01
        for (int i = 0; i < 4; i++) begin
            apply(ahead(cur), 1, 0, 0, "R2 forward");
            pos++;
        end
        // R3 and R8: full reverse cycle
        for (int i = 0; i < 4; i++) begin
            apply(behind(cur), 0, 1, 0, "R3 reverse");
            pos--;
        end
        check_eq("R8 four counts per cycle", tot_up - tot_dn, pos);

        // R6: both bits flip together, then decoding resumes from new phase
        apply(cur ^ 2'b11, 0, 0, 1, "R6 double flip");
        apply(ahead(cur), 1, 0, 0, "R6 resume forward");
        pos++;

        // R5: short glitches on each line, then a step from the old phase
        glitch(2'b10, FLEN - 1);
        glitch(2'b01, FLEN - 1);
        glitch(2'b10, 1);
        apply(behind(cur), 0, 1, 0, "R5 old phase kept");
        pos--;

        // Random walk mixing legal steps, stills and double flips
        for (int i = 0; i < 300; i++) begin
            int r;
            r = int'($urandom % 8);
            if (r < 3) begin
                apply(ahead(cur), 1, 0, 0, "R2 random forward");
                pos++;
            end else if (r < 6) begin
                apply(behind(cur), 0, 1, 0, "R3 random reverse");
                pos--;
            end else if (r == 6) begin
                apply(cur, 0, 0, 0, "R9 random still");
            end else begin
                apply(cur ^ 2'b11, 0, 0, 1, "R6 random double flip");
            end
        end
        check_eq("R8 net count equals position", tot_up - tot_dn, pos);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule